// File: doc/BRIEF.md
# Externally Synced Serial Transmitter

This block is the transmit side of a frame-synchronous serial port. The frame sync comes from an outside master and is never generated locally. The whole block runs on the bit clock. A host writes words into a holding register. Each detected rising edge of the frame-sync input copies the holding register into a shift register, if the host has written new data since the last copy. The word then goes out on the serial pin, most significant bit first, one bit per bit-clock cycle, for a programmable word length.

A single enable bit holds the transmitter in reset or lets it run. Frame-sync detection and its interrupt keep working while the transmitter is held in reset. This lets a host use the first frame-sync interrupt as the cue to fill the holding register and then enable the transmitter. Once enabled, the transmitter stays silent until the next frame sync. If no new word was written in time, the transmitter resends the content its shift register already holds. A frame sync that lands in the middle of a word sets a sticky error flag, which the host can clear.

Top module: `ext_sync_tx`

## Requirements
- R1: After synchronous reset: `sdata_out`=0, `sdata_oe`=0, `tx_ready`=1, `sync_err`=0, `irq`=0.
- R2: The frame-sync input passes through two sampling stages. A rising edge is detected only when it is sampled at clock edge k, and it is acted on at edge k+2. Detection is suppressed for the first three clock edges after reset, so a frame sync that is already high when reset ends is not taken as an edge. While enabled and idle, nothing starts without a detected edge.
- R3: When a frame-sync edge is acted on while enabled, the serial word starts after that edge. It is `wlen_m1`+1 bits long, sent MSB first with one bit per cycle, and `sdata_oe` is high for exactly those cycles. `sdata_out` is 0 whenever `sdata_oe` is 0.
- R4: If the holding register has not been written since its last copy (`tx_ready`=1), a frame sync resends the current shift-register content. Right after the transmitter leaves reset, that content is the parameter `SR_INIT`.
- R5: `tx_ready` is cleared by a host write and set when the holding register is copied at a frame sync. When a write and a copy happen in the same cycle, the old value is copied, the new value stays pending, and `tx_ready` is 0.
- R6: While `tx_en`=0, no output is driven and writes are still accepted. After `tx_en` rises, nothing is sent until the next frame-sync edge, even in the middle of an external frame.
- R7: A frame-sync edge acted on while enabled and busy, with more than one bit of the word left, sets `sync_err` and restarts the word. An edge that coincides with the last bit is a back-to-back frame and is not an error.
- R8: `sync_err` stays set until `err_clr` is high. If an error and a clear happen in the same cycle, the error wins.
- R9: `irq` is a one-cycle pulse in the cycle after the event edge. The event depends on `int_mode`: 0 = holding register copied, 1 = last bit of a word sent, 2 = frame-sync edge detected, 3 = sync error.
- R10: With `int_mode`=2, frame-sync edges raise `irq` even while `tx_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | 1 = transmitter runs, 0 = held in reset |
| int_mode | input | 2 | Interrupt event select |
| wlen_m1 | input | 4 | Word length minus one |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| err_clr | input | 1 | Clears the sync error flag |
| fsync_in | input | 1 | External frame sync |
| sdata_out | output | 1 | Serial data |
| sdata_oe | output | 1 | Serial data valid/drive |
| tx_ready | output | 1 | Holding register free for a write |
| sync_err | output | 1 | Sticky sync error |
| irq | output | 1 | Interrupt pulse |

## Verification
The transmitter is driven with full 16-bit words, 8-bit words, an unwritten register right after enable, and frame syncs that arrive back to back. Together these separate correct loading and bit order from resending stale data and from word-boundary handling. A frame sync that arrives early in a word and a clear held during an error show whether the sticky flag and its priority are right. Frame syncs during reset, with every interrupt mode selected in turn, show that detection runs apart from the enable. A frame sync held high through reset release shows that the settle window masks it.

// File: rtl/ext_tx_pkg.sv
package ext_tx_pkg;

    typedef enum logic [1:0] {
        IRQ_ON_LOAD  = 2'd0,
        IRQ_ON_DONE  = 2'd1,
        IRQ_ON_FSYNC = 2'd2,
        IRQ_ON_ERR   = 2'd3
    } irq_sel_e;

    typedef struct packed {
        logic load;
        logic done;
        logic fsync;
        logic serr;
    } tx_evt_t;

    function automatic logic irq_pick(irq_sel_e sel, tx_evt_t ev);
        logic r;
        case (sel)
            IRQ_ON_LOAD:  r = ev.load;
            IRQ_ON_DONE:  r = ev.done;
            IRQ_ON_FSYNC: r = ev.fsync;
            default:      r = ev.serr;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ets_fsync_detect.sv
module ets_fsync_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fsync_in,
    output logic det
);
    localparam int ST_MAX = SYNC_STAGES + 1;
    localparam int ST_W   = $clog2(ST_MAX + 1);

    logic [SYNC_STAGES:0] pipe;
    logic [ST_W-1:0]      settle;
    logic                 armed;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b0;
        else     pipe[0] <= fsync_in;
    end

    for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= 1'b0;
            else     pipe[i] <= pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         settle <= '0;
        else if (!armed) settle <= settle + 1'b1;
    end

    assign armed = (settle == ST_W'(ST_MAX));
    assign det   = armed & pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

    AST_DET_PULSE: assert property (@(posedge clk) disable iff (rst)
        det |=> !det);  // R2
    AST_DET_SETTLE: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> !det);  // R2

endmodule

// File: rtl/ets_datapath.sv
module ets_datapath
    import ext_tx_pkg::*;
#(
    parameter int              WORD_W  = 16,
    parameter logic [WORD_W-1:0] SR_INIT = '0,
    localparam int LEN_W = $clog2(WORD_W),
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              det,
    input  logic [LEN_W-1:0]  wlen_m1,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              sdata_out,
    output logic              sdata_oe,
    output logic              tx_ready,
    output tx_evt_t           evt
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;
    logic              busy_q;
    logic              start;
    logic              copy;
    logic              last_bit;
    logic [IDX_W-1:0]  bit_idx;

    assign start    = det & tx_en;
    assign copy     = start & ~tx_ready;
    assign last_bit = busy_q & (left_q == CNT_W'(1));

    always_comb begin
        evt       = '0;
        evt.load  = copy;
        evt.done  = tx_en & last_bit;
        evt.fsync = det;
        evt.serr  = start & busy_q & ~last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            tx_ready <= 1'b1;
        end else begin
            if (copy)  tx_ready <= 1'b1;
            if (wr_en) begin
                hold_q   <= wr_data;
                tx_ready <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            shreg_q <= SR_INIT;
            busy_q  <= 1'b0;
            left_q  <= '0;
        end else if (start) begin
            if (copy) shreg_q <= hold_q;
            busy_q <= 1'b1;
            left_q <= CNT_W'(wlen_m1) + CNT_W'(1);
        end else if (busy_q) begin
            if (last_bit) busy_q <= 1'b0;
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_idx   = IDX_W'(left_q - CNT_W'(1));
    assign sdata_oe  = busy_q;
    assign sdata_out = busy_q & shreg_q[bit_idx];

    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (left_q != '0) && (left_q <= CNT_W'(WORD_W)));  // R3
    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !sdata_oe && !sdata_out);  // R6
    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_ready);  // R5
    AST_NO_START_WITHOUT_SYNC: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !det && !busy_q) |=> !sdata_oe);  // R2

endmodule

// File: rtl/ets_status.sv
module ets_status
    import ext_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tx_evt_t  evt,
    input  irq_sel_e sel,
    input  logic     err_clr,
    output logic     sync_err,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_err <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (evt.serr)     sync_err <= 1'b1;
            else if (err_clr) sync_err <= 1'b0;
            irq <= irq_pick(sel, evt);
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sync_err && !err_clr) |=> sync_err);  // R8
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt.serr |=> sync_err);  // R7

endmodule

// File: rtl/ext_sync_tx.sv
module ext_sync_tx
    import ext_tx_pkg::*;
#(
    parameter int                WORD_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] SR_INIT     = 16'h96C3,
    localparam int LEN_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [1:0]        int_mode,
    input  logic [LEN_W-1:0]  wlen_m1,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              err_clr,
    input  logic              fsync_in,
    output logic              sdata_out,
    output logic              sdata_oe,
    output logic              tx_ready,
    output logic              sync_err,
    output logic              irq
);
    logic    det;
    tx_evt_t evt;

    ets_fsync_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk      (clk),
        .rst      (rst),
        .fsync_in (fsync_in),
        .det      (det)
    );

    ets_datapath #(.WORD_W(WORD_W), .SR_INIT(SR_INIT)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .det       (det),
        .wlen_m1   (wlen_m1),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sdata_out (sdata_out),
        .sdata_oe  (sdata_oe),
        .tx_ready  (tx_ready),
        .evt       (evt)
    );

    ets_status u_st (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sel      (irq_sel_e'(int_mode)),
        .err_clr  (err_clr),
        .sync_err (sync_err),
        .irq      (irq)
    );

    AST_FSYNC_IRQ_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        (int_mode == 2'd2 && det) |=> irq);  // R10
    AST_IRQ_MODE_FSYNC: assert property (@(posedge clk) disable iff (rst)
        (int_mode == 2'd2 && !det) |=> !irq);  // R9

endmodule

// File: tb/ext_sync_tx_test.sv
module ext_sync_tx_test;
    localparam int         W    = 16;
    localparam logic [15:0] INIT = 16'h96C3;

    logic clk = 1'b0;
    logic rst = 1'b1, tx_en = 1'b0, wr_en = 1'b0, err_clr = 1'b0, fsync_in = 1'b0;
    logic [1:0]  int_mode = 2'd2;
    logic [3:0]  wlen_m1 = 4'd15;
    logic [15:0] wr_data = '0;
    logic sdata_out, sdata_oe, tx_ready, sync_err, irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ext_sync_tx #(.WORD_W(W), .SYNC_STAGES(2), .SR_INIT(INIT)) uut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .int_mode(int_mode), .wlen_m1(wlen_m1),
        .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr), .fsync_in(fsync_in),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .tx_ready(tx_ready),
        .sync_err(sync_err), .irq(irq));

    // behavioural reference model
    bit [2:0]  m_hist;
    int        m_settle, m_len, m_pos;
    bit        m_busy, m_ready, m_err, m_irq;
    bit [15:0] m_word, m_hold;

    always @(posedge clk) begin
        if (rst) begin
            m_hist = '0; m_settle = 0; m_busy = 0; m_len = 0; m_pos = 0;
            m_ready = 1; m_err = 0; m_irq = 0; m_word = INIT; m_hold = '0;
        end else begin
            bit seen, go, early, fin, cp;
            seen  = m_hist[1] && !m_hist[2] && (m_settle >= 3);
            go    = seen && tx_en;
            fin   = tx_en && m_busy && (m_len - m_pos == 1);
            early = go && m_busy && (m_len - m_pos != 1);
            cp    = go && !m_ready;
            case (int_mode)
                2'd0: m_irq = cp;
                2'd1: m_irq = fin;
                2'd2: m_irq = seen;
                default: m_irq = early;
            endcase
            if (early) m_err = 1; else if (err_clr) m_err = 0;
            if (!tx_en) begin
                m_busy = 0; m_pos = 0; m_word = INIT;
            end else if (go) begin
                if (cp) m_word = m_hold;
                m_busy = 1; m_pos = 0; m_len = int'(wlen_m1) + 1;
            end else if (m_busy) begin
                m_pos++;
                if (m_pos == m_len) m_busy = 0;
            end
            if (cp) m_ready = 1;
            if (wr_en) begin m_hold = wr_data; m_ready = 0; end
            m_hist = {m_hist[1:0], fsync_in};
            if (m_settle < 3) m_settle++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    bit cmp_on = 0;
    always @(negedge clk) if (cmp_on && !rst) begin
        bit exp_d;
        exp_d = m_busy ? m_word[m_len - 1 - m_pos] : 1'b0;
        chk(sdata_oe == m_busy, "R3 oe", sdata_oe, m_busy);
        chk(sdata_out == exp_d, "R3/R4 sdata", sdata_out, exp_d);
        chk(tx_ready == m_ready, "R5 ready", tx_ready, m_ready);
        chk(sync_err == m_err, "R7/R8 sync_err", sync_err, m_err);
        chk(irq == m_irq, "R9 irq", irq, m_irq);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_fs();
        fsync_in = 1; cyc(1); fsync_in = 0;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1; wr_data = d; cyc(1); wr_en = 0;
    endtask

    // pulse frame sync, then collect the serial word bit by bit
    task automatic send_and_grab(input int nbits, output logic [15:0] got, output int seen_bits);
        got = '0; seen_bits = 0;
        pulse_fs();
        cyc(2);
        while (sdata_oe && seen_bits < 16) begin
            got = {got[14:0], sdata_out};
            seen_bits++;
            cyc(1);
        end
        if (nbits < 0) seen_bits = seen_bits; // unused path guard
    endtask

    initial begin
        logic [15:0] g;
        int n;
        cyc(3);
        chk(sdata_out == 0 && sdata_oe == 0, "R1 outputs", {sdata_out, sdata_oe}, 0);
        chk(tx_ready == 1, "R1 ready", tx_ready, 1);
        chk(sync_err == 0 && irq == 0, "R1 flags", {sync_err, irq}, 0);
        rst = 0; cmp_on = 1;
        cyc(5);

        // R10: detection and irq while held in reset; R6 nothing driven
        pulse_fs(); cyc(1);
        chk(irq == 0, "R2 latency", irq, 0);
        cyc(1);
        chk(irq == 1, "R10 irq in reset", irq, 1);
        chk(sdata_oe == 0, "R6 quiet in reset", sdata_oe, 0);
        cyc(4);

        // R4: enable without a write, stale default goes out
        tx_en = 1; cyc(3);
        chk(sdata_oe == 0, "R6 wait for sync", sdata_oe, 0);
        send_and_grab(16, g, n);
        chk(g == INIT && n == 16, "R4 default word", g, INIT);
        cyc(3);

        // R3/R5: 16-bit word
        wr(16'hBEEF);
        chk(tx_ready == 0, "R5 ready cleared", tx_ready, 0);
        send_and_grab(16, g, n);
        chk(g == 16'hBEEF && n == 16, "R3 word 16", g, 16'hBEEF);
        chk(tx_ready == 1, "R5 ready after copy", tx_ready, 1);
        // R4: unwritten -> previous word resent
        send_and_grab(16, g, n);
        chk(g == 16'hBEEF, "R4 resend", g, 16'hBEEF);

        // R3: 8-bit word
        wlen_m1 = 4'd7; wr(16'h005A);
        send_and_grab(8, g, n);
        chk(g == 16'h005A && n == 8, "R3 word 8", g, 16'h005A);
        cyc(2);

        // R7: back-to-back 8-bit frames, no error
        for (int k = 0; k < 4; k++) begin
            pulse_fs(); cyc(7);
        end
        cyc(10);
        chk(sync_err == 0, "R7 back-to-back", sync_err, 0);

        // R7: early frame sync mid-word
        wlen_m1 = 4'd15; wr(16'h1234);
        pulse_fs(); cyc(6); pulse_fs(); cyc(2);
        chk(sync_err == 1, "R7 early sync", sync_err, 1);
        cyc(20);
        // R8 clear
        err_clr = 1; cyc(1); err_clr = 0;
        chk(sync_err == 0, "R8 clear", sync_err, 0);
        // R8 set wins over clear
        pulse_fs(); cyc(4);
        err_clr = 1; pulse_fs(); cyc(2);
        chk(sync_err == 1, "R8 set wins", sync_err, 1);
        err_clr = 0; cyc(20);
        err_clr = 1; cyc(1); err_clr = 0;

        // R5: write colliding with copy
        wr(16'hA001);
        fsync_in = 1; cyc(1); fsync_in = 0; cyc(1);
        wr(16'h0F0F);
        chk(tx_ready == 0, "R5 collide pending", tx_ready, 0);
        cyc(20);

        // R9: other interrupt modes
        for (int md = 0; md < 4; md++) begin
            int_mode = 2'(md);
            wr(16'h8001);
            pulse_fs(); cyc(5); pulse_fs(); cyc(25);
        end
        int_mode = 2'd2;
        err_clr = 1; cyc(1); err_clr = 0;

        // R6: release mid external frame waits for next sync
        tx_en = 0; wr(16'hC0DE); pulse_fs(); cyc(4);
        tx_en = 1; cyc(10);
        chk(sdata_oe == 0, "R6 mid-frame release", sdata_oe, 0);
        send_and_grab(16, g, n);
        chk(g == 16'hC0DE, "R6 first word", g, 16'hC0DE);

        // R2: frame sync high through reset release is ignored
        cmp_on = 0; rst = 1; fsync_in = 1; cyc(3); rst = 0; cmp_on = 1;
        cyc(8);
        chk(sdata_oe == 0 && irq == 0, "R2 level at reset", {sdata_oe, irq}, 0);
        fsync_in = 0; cyc(5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule